// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block sits between a CPU's data-memory request port and a set of device pins that reach an external asynchronous SRAM. The low address byte and the data byte share one 8-bit bidirectional port, and the high address byte has its own output port. A one-cycle address strobe lets an external transparent latch, open while the strobe is high, capture the low byte as the strobe falls. Active-low read and write strobes then run the data phase. The strobe phase can be stretched by 0 to 3 wait cycles.

Each request is classified against a parameterized internal-SRAM top address. Addresses at or below it go to a small internal memory inside the block. Addresses above it go to the external bus, but only while the bus is enabled. When the bus is disabled, such requests complete without touching any memory, and reads return zero. While enabled, the block owns the pins and sets their output values and direction. It runs the address phase and the address strobe for internal accesses as well, but keeps the read and write strobes high for them. While disabled, every pin follows the general-purpose port values and directions supplied from outside.

All accesses share one cycle sequence: address phase, latch phase, strobe phase of 1+N cycles, and finish. The CPU sees a one-cycle `cpu_ready` pulse in the finish cycle.

Top module: `xbus_ctrl`

## Requirements
- R1: An external read returns, on `cpu_rdata`, the byte present on `ad_i` during the last strobe cycle. An external write stores `cpu_wdata` at the full 16-bit address in the external memory.
- R2: `ctl_o[0]` (address strobe, active high) is high for exactly one cycle per access. During that cycle `ad_o` carries address bits 7:0 and `hi_o` carries address bits 15:8. In the cycle after the strobe falls, `ad_o` still holds the low address byte with all bits of `ad_oe` set.
- R3: For an external read, `ctl_o[1]` (read strobe, active low) is low for 1+N consecutive cycles, and `ad_oe` is 0 throughout. For an external write, `ctl_o[2]` (write strobe, active low) is low for 1+N cycles with `cpu_wdata` driven. The write data stays driven for one cycle after the write strobe returns high. The two strobes are never low together.
- R4: With the bus enabled, an internal access pulses the address strobe once, keeps both the read and write strobes high, and reads and writes the internal memory.
- R5: With `xmem_en` low, `ad_o`, `ad_oe`, `hi_o`, `hi_oe`, `ctl_o` and `ctl_oe` equal `port_ad_o`, `port_ad_dir`, `port_hi_o`, `port_hi_dir`, `port_ctl_o` and `port_ctl_dir` respectively.
- R6: With the bus disabled, an access above the internal top address does not change the internal memory at any address, and a read of it returns 0.
- R7: `cpu_ready` is high for exactly one cycle, in the 4+N-th cycle after the cycle in which the request is accepted. This holds for every access kind.
- R8: The wait count N is taken from `wait_sel` when the request is accepted. Changing `wait_sel` during an access does not change that access.
- R9: Dropping `xmem_en` during an external access returns the pins to the port values in the same cycle, and the access still completes with unchanged latency.
- R10: An address equal to the internal top address (default 0x00FF) is internal. The next address (0x0100) is external.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmem_en | input | 1 | External bus enable; pins are overridden while high |
| cpu_req | input | 1 | Request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 8 | Write data |
| wait_sel | input | 2 | Extra strobe cycles N, 0 to 3 |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read data, valid with `cpu_ready` |
| ad_o | output | 8 | Shared address/data port output value |
| ad_oe | output | 8 | Shared port per-bit output enable |
| ad_i | input | 8 | Shared port pin value |
| hi_o | output | 8 | High address port value |
| hi_oe | output | 8 | High address port per-bit output enable |
| ctl_o | output | 3 | Control pins: bit 0 address strobe, bit 1 read strobe (low active), bit 2 write strobe (low active) |
| ctl_oe | output | 3 | Control pin output enables |
| port_ad_o | input | 8 | General-purpose value for the shared port |
| port_ad_dir | input | 8 | General-purpose direction for the shared port |
| port_hi_o | input | 8 | General-purpose value for the high port |
| port_hi_dir | input | 8 | General-purpose direction for the high port |
| port_ctl_o | input | 3 | General-purpose value for the control pins |
| port_ctl_dir | input | 3 | General-purpose direction for the control pins |

## Verification
The enable can fall while an external access is in its strobe phase. The pin override and the access sequencer then act in the same cycle: one releases the pins, and the other continues to count the strobe. The bench provokes this by dropping `xmem_en` in the first strobe cycle of a read with two wait states. It judges the result by comparing every pin with its port value on each later cycle, and by requiring `cpu_ready` to arrive exactly in cycle 6. A second overlap comes from changing `wait_sel` in mid-access. This is judged by the strobe length and latency staying at their accepted value.

// File: rtl/xbus_pkg.sv
// Shared types for the multiplexed external bus controller.
// Assumes: control pin vector order is fixed by the CTL_* indices below.
package xbus_pkg;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_LATCH,
        XS_STRB,
        XS_FIN
    } xs_state_t;

    typedef enum logic [1:0] {
        HIT_NONE,
        HIT_INT,
        HIT_EXT
    } hit_t;

    localparam int CTL_W   = 3;
    localparam int CTL_ALE = 0;
    localparam int CTL_RD  = 1;
    localparam int CTL_WR  = 2;

endpackage

// File: rtl/xbus_intram.sv
// Internal data memory: combinational read, synchronous write.
// Assumes: the sequencer presents a stable address for the whole access.
module xbus_intram #(
    parameter int DW    = 8,
    parameter int DEPTH = 256,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store one byte when the sequencer commits an internal write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Present the addressed byte without a clock delay.
    always_comb begin
        rdata = mem[addr];
    end

endmodule

// File: rtl/xbus_seq.sv
// Access sequencer: accepts a CPU request, classifies it as internal,
// external or no-hit, and steps address, latch, strobe and finish phases.
// Produces bus-side values before the pin override.
// Assumes: the CPU holds its request until the ready pulse and drops it then.
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int WAIT_W  = 2,
    parameter int INT_TOP = 255,
    parameter int IW      = 8,
    localparam int HW     = AW - DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              req,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic [DW-1:0]     ad_in,
    input  logic [DW-1:0]     ram_rdata,
    output logic              ready,
    output logic [DW-1:0]     rdata,
    output logic              ram_we,
    output logic [IW-1:0]     ram_addr,
    output logic [DW-1:0]     ram_wdata,
    output logic [DW-1:0]     bus_ad,
    output logic              bus_ad_oe,
    output logic [HW-1:0]     bus_hi,
    output logic              bus_ale,
    output logic              bus_rd_n,
    output logic              bus_wr_n
);

    localparam logic [AW-1:0] TOP_A = AW'(INT_TOP);

    xs_state_t         st;
    hit_t              hit_q;
    logic [AW-1:0]     a_q;
    logic              we_q;
    logic [DW-1:0]     wd_q;
    logic [WAIT_W-1:0] cnt_q;
    logic [DW-1:0]     rdata_q;
    logic              ext_rd;
    logic              ext_wr;
    logic              last_strb;

    // Decide where an address lands given the current enable.
    function automatic hit_t classify(input logic [AW-1:0] a, input logic e);
        if (a <= TOP_A) begin
            return HIT_INT;
        end else if (e) begin
            return HIT_EXT;
        end
        return HIT_NONE;
    endfunction

    assign ext_rd    = (hit_q == HIT_EXT) && !we_q;
    assign ext_wr    = (hit_q == HIT_EXT) && we_q;
    assign last_strb = (st == XS_STRB) && (cnt_q == '0);

    // Step the phase sequence and capture request fields and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= XS_IDLE;
            hit_q   <= HIT_NONE;
            a_q     <= '0;
            we_q    <= 1'b0;
            wd_q    <= '0;
            cnt_q   <= '0;
            rdata_q <= '0;
        end else begin
            case (st)
                XS_IDLE: begin
                    if (req) begin
                        st    <= XS_ADDR;
                        hit_q <= classify(addr, en);
                        a_q   <= addr;
                        we_q  <= we;
                        wd_q  <= wdata;
                        cnt_q <= wait_sel;
                    end
                end
                XS_ADDR:  st <= XS_LATCH;
                XS_LATCH: st <= XS_STRB;
                XS_STRB: begin
                    if (cnt_q == '0) begin
                        st <= XS_FIN;
                        case (hit_q)
                            HIT_EXT: rdata_q <= ad_in;
                            HIT_INT: rdata_q <= ram_rdata;
                            default: rdata_q <= '0;
                        endcase
                    end else begin
                        cnt_q <= cnt_q - WAIT_W'(1);
                    end
                end
                XS_FIN:   st <= XS_IDLE;
                default:  st <= XS_IDLE;
            endcase
        end
    end

    // Drive bus-side pin values from the current phase.
    always_comb begin
        bus_hi    = a_q[AW-1:DW];
        bus_ale   = (st == XS_ADDR);
        bus_rd_n  = !((st == XS_STRB) && ext_rd);
        bus_wr_n  = !((st == XS_STRB) && ext_wr);
        bus_ad    = a_q[DW-1:0];
        bus_ad_oe = 1'b1;
        case (st)
            XS_STRB: begin
                if (ext_rd) begin
                    bus_ad_oe = 1'b0;
                end else begin
                    bus_ad = we_q ? wd_q : ram_rdata;
                end
            end
            XS_FIN: begin
                if (ext_rd) begin
                    bus_ad_oe = 1'b0;
                end else if (we_q) begin
                    bus_ad = wd_q;
                end
            end
            default: ;
        endcase
    end

    // Expose CPU-side results and internal memory controls.
    always_comb begin
        ready     = (st == XS_FIN);
        rdata     = rdata_q;
        ram_we    = last_strb && (hit_q == HIT_INT) && we_q;
        ram_addr  = a_q[IW-1:0];
        ram_wdata = wd_q;
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale); // R2
    AST_ALE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_ale) |-> (bus_ad_oe && bus_ad == $past(bus_ad))); // R2
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n)); // R3
    AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_ad_oe); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr_n) |-> (bus_ad_oe && bus_ad == $past(bus_ad))); // R3
    AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q != HIT_EXT) |-> (bus_rd_n && bus_wr_n)); // R4
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready); // R7
    AST_NO_RAM_WRITE_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q == HIT_NONE) |-> !ram_we); // R6

endmodule

// File: rtl/xbus_padmux.sv
// Pin override: while the bus is enabled the sequencer owns values and
// directions of all bus pins; otherwise the general-purpose port settings pass.
// Assumes: enable acts on the pins combinationally (no registered handover).
module xbus_padmux
    import xbus_pkg::*;
#(
    parameter int DW = 8,
    parameter int HW = 8
) (
    input  logic             en,
    input  logic [DW-1:0]    bus_ad,
    input  logic             bus_ad_oe,
    input  logic [HW-1:0]    bus_hi,
    input  logic             bus_ale,
    input  logic             bus_rd_n,
    input  logic             bus_wr_n,
    input  logic [DW-1:0]    port_ad_o,
    input  logic [DW-1:0]    port_ad_dir,
    input  logic [HW-1:0]    port_hi_o,
    input  logic [HW-1:0]    port_hi_dir,
    input  logic [CTL_W-1:0] port_ctl_o,
    input  logic [CTL_W-1:0] port_ctl_dir,
    output logic [DW-1:0]    ad_o,
    output logic [DW-1:0]    ad_oe,
    output logic [HW-1:0]    hi_o,
    output logic [HW-1:0]    hi_oe,
    output logic [CTL_W-1:0] ctl_o,
    output logic [CTL_W-1:0] ctl_oe
);

    logic [CTL_W-1:0] bus_ctl;

    // Pack the control pins in their fixed bit order.
    always_comb begin
        bus_ctl          = '0;
        bus_ctl[CTL_ALE] = bus_ale;
        bus_ctl[CTL_RD]  = bus_rd_n;
        bus_ctl[CTL_WR]  = bus_wr_n;
    end

    // Select bus or port ownership for every pin group.
    always_comb begin
        if (en) begin
            ad_o   = bus_ad;
            ad_oe  = {DW{bus_ad_oe}};
            hi_o   = bus_hi;
            hi_oe  = '1;
            ctl_o  = bus_ctl;
            ctl_oe = '1;
        end else begin
            ad_o   = port_ad_o;
            ad_oe  = port_ad_dir;
            hi_o   = port_hi_o;
            hi_oe  = port_hi_dir;
            ctl_o  = port_ctl_o;
            ctl_oe = port_ctl_dir;
        end
    end

endmodule

// File: rtl/xbus_ctrl.sv
// Multiplexed external memory bus controller, top level.
// Joins the sequencer, the internal memory and the pin override.
// Assumes: INT_TOP+1 is a power of two sized internal memory; the external
// address latch is transparent while the address strobe is high.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int WAIT_W  = 2,
    parameter int INT_TOP = 255,
    localparam int HW     = AW - DW,
    localparam int DEPTH  = INT_TOP + 1,
    localparam int IW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmem_en,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [WAIT_W-1:0] wait_sel,
    output logic              cpu_ready,
    output logic [DW-1:0]     cpu_rdata,
    output logic [DW-1:0]     ad_o,
    output logic [DW-1:0]     ad_oe,
    input  logic [DW-1:0]     ad_i,
    output logic [HW-1:0]     hi_o,
    output logic [HW-1:0]     hi_oe,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [CTL_W-1:0]  ctl_oe,
    input  logic [DW-1:0]     port_ad_o,
    input  logic [DW-1:0]     port_ad_dir,
    input  logic [HW-1:0]     port_hi_o,
    input  logic [HW-1:0]     port_hi_dir,
    input  logic [CTL_W-1:0]  port_ctl_o,
    input  logic [CTL_W-1:0]  port_ctl_dir
);

    logic          ram_we;
    logic [IW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] bus_ad;
    logic          bus_ad_oe;
    logic [HW-1:0] bus_hi;
    logic          bus_ale;
    logic          bus_rd_n;
    logic          bus_wr_n;

    xbus_seq #(
        .AW(AW), .DW(DW), .WAIT_W(WAIT_W), .INT_TOP(INT_TOP), .IW(IW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .en(xmem_en),
        .req(cpu_req), .we(cpu_we), .addr(cpu_addr), .wdata(cpu_wdata),
        .wait_sel(wait_sel), .ad_in(ad_i), .ram_rdata(ram_rdata),
        .ready(cpu_ready), .rdata(cpu_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe), .bus_hi(bus_hi),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
    );

    xbus_intram #(
        .DW(DW), .DEPTH(DEPTH)
    ) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    xbus_padmux #(
        .DW(DW), .HW(HW)
    ) u_pad (
        .en(xmem_en),
        .bus_ad(bus_ad), .bus_ad_oe(bus_ad_oe), .bus_hi(bus_hi),
        .bus_ale(bus_ale), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .port_ad_o(port_ad_o), .port_ad_dir(port_ad_dir),
        .port_hi_o(port_hi_o), .port_hi_dir(port_hi_dir),
        .port_ctl_o(port_ctl_o), .port_ctl_dir(port_ctl_dir),
        .ad_o(ad_o), .ad_oe(ad_oe), .hi_o(hi_o), .hi_oe(hi_oe),
        .ctl_o(ctl_o), .ctl_oe(ctl_oe)
    );

    AST_PINS_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        xmem_en |-> (ctl_o[CTL_RD] || ctl_o[CTL_WR])); // R3

endmodule

// File: tb/tb_xbus_ctrl.sv
// Bench for xbus_ctrl: sweeps wait counts, address ranges and enable states
// against an external latch and SRAM model, with expectations computed here.
module tb_xbus_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        xmem_en;
    logic        cpu_req;
    logic        cpu_we;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic [1:0]  wait_sel;
    logic        cpu_ready;
    logic [7:0]  cpu_rdata;
    logic [7:0]  ad_o, ad_oe, ad_i, hi_o, hi_oe;
    logic [2:0]  ctl_o, ctl_oe;
    logic [7:0]  port_ad_o, port_ad_dir, port_hi_o, port_hi_dir;
    logic [2:0]  port_ctl_o, port_ctl_dir;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    xbus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .xmem_en(xmem_en),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .wait_sel(wait_sel),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
        .hi_o(hi_o), .hi_oe(hi_oe), .ctl_o(ctl_o), .ctl_oe(ctl_oe),
        .port_ad_o(port_ad_o), .port_ad_dir(port_ad_dir),
        .port_hi_o(port_hi_o), .port_hi_dir(port_hi_dir),
        .port_ctl_o(port_ctl_o), .port_ctl_dir(port_ctl_dir)
    );

    // External latch and SRAM model (addresses 0x0000-0x03FF are unique).
    logic [7:0] ext_lat = 8'h00;
    logic [7:0] ext_mem [1024];
    logic [7:0] sram_q;
    logic       sram_oe;

    always_latch begin
        if (ctl_oe[0] && ctl_o[0]) ext_lat = ad_o;
    end
    assign sram_q  = ext_mem[{hi_o[1:0], ext_lat}];
    assign sram_oe = ctl_oe[1] && !ctl_o[1];
    assign ad_i    = (ad_o & ad_oe) | (sram_oe ? (sram_q & ~ad_oe) : 8'h00);

    always @(negedge clk) begin
        if (ctl_oe[2] && !ctl_o[2]) ext_mem[{hi_o[1:0], ext_lat}] <= ad_i;
    end

    // Results of the most recent access.
    int         m_lat, m_ale, m_rd, m_wr, m_revert_bad;
    logic [7:0] m_lat_addr, m_hi, m_rdata;
    logic       m_hold_ok, m_wrhold_ok, m_wdrive_ok, m_rel_ok, m_pulse_ok;
    logic [7:0] exp_ext [1024];
    logic [7:0] exp_int [256];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic run_acc(input logic w, input logic [15:0] a, input logic [7:0] d,
                           input int nw, input int chg_wait_at, input int drop_en_at);
        int c;
        logic done, prev_ale, prev_wr, ale, rdn, wrn;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
        wait_sel = 2'(nw);
        m_lat = -1; m_ale = 0; m_rd = 0; m_wr = 0; m_revert_bad = 0;
        m_lat_addr = 8'h00; m_hi = 8'h00; m_rdata = 8'h00;
        m_hold_ok = 1'b0; m_wrhold_ok = 1'b0; m_wdrive_ok = 1'b1; m_rel_ok = 1'b1;
        prev_ale = 1'b0; prev_wr = 1'b1;
        c = 0; done = 1'b0;
        while (!done && c < 40) begin
            @(negedge clk);
            c++;
            if (!xmem_en) begin
                if (ad_o != port_ad_o || ad_oe != port_ad_dir || hi_o != port_hi_o ||
                    hi_oe != port_hi_dir || ctl_o != port_ctl_o || ctl_oe != port_ctl_dir)
                    m_revert_bad++;
            end else begin
                ale = ctl_o[0]; rdn = ctl_o[1]; wrn = ctl_o[2];
                if (ale) begin m_ale++; m_lat_addr = ad_o; m_hi = hi_o; end
                if (!ale && prev_ale) m_hold_ok = (ad_oe == 8'hFF) && (ad_o == a[7:0]);
                if (!rdn) begin m_rd++; if (ad_oe != 8'h00) m_rel_ok = 1'b0; end
                if (!wrn) begin
                    m_wr++;
                    if (ad_o != d || ad_oe != 8'hFF) m_wdrive_ok = 1'b0;
                end
                if (wrn && !prev_wr) m_wrhold_ok = (ad_oe == 8'hFF) && (ad_o == d);
                prev_ale = ale; prev_wr = wrn;
            end
            if (c == chg_wait_at) wait_sel = 2'd3;
            if (c == drop_en_at) xmem_en = 1'b0;
            if (cpu_ready) begin
                m_lat = c; m_rdata = cpu_rdata; done = 1'b1; cpu_req = 1'b0;
            end
        end
        cpu_req = 1'b0;
        @(negedge clk);
        m_pulse_ok = !cpu_ready;
    endtask

    // Checks shared by all external accesses.
    task automatic ext_write(input logic [15:0] a, input logic [7:0] d, input int nw);
        run_acc(1'b1, a, d, nw, -1, -1);
        exp_ext[a[9:0]] = d;
        chk("R7", "ext write latency", m_lat, 4 + nw);
        chk("R7", "ready single pulse", int'(m_pulse_ok), 1);
        chk("R3", "write strobe cycles", m_wr, 1 + nw);
        chk("R3", "read strobe idle on write", m_rd, 0);
        chk("R3", "write data driven in strobe", int'(m_wdrive_ok), 1);
        chk("R3", "write data held after strobe", int'(m_wrhold_ok), 1);
        chk("R2", "strobe high cycles", m_ale, 1);
        chk("R2", "low address at strobe", int'(m_lat_addr), int'(a[7:0]));
        chk("R2", "high address port", int'(m_hi), int'(a[15:8]));
        chk("R2", "address hold after strobe fall", int'(m_hold_ok), 1);
    endtask

    task automatic ext_read(input logic [15:0] a, input int nw);
        run_acc(1'b0, a, 8'h00, nw, -1, -1);
        chk("R7", "ext read latency", m_lat, 4 + nw);
        chk("R3", "read strobe cycles", m_rd, 1 + nw);
        chk("R3", "write strobe idle on read", m_wr, 0);
        chk("R3", "port released in read strobe", int'(m_rel_ok), 1);
        chk("R2", "low address at strobe (read)", int'(m_lat_addr), int'(a[7:0]));
        chk("R1", "ext read data", int'(m_rdata), int'(exp_ext[a[9:0]]));
    endtask

    task automatic int_acc(input logic w, input logic [15:0] a, input logic [7:0] d, input int nw);
        run_acc(w, a, d, nw, -1, -1);
        chk("R4", "internal: read strobe stays high", m_rd, 0);
        chk("R4", "internal: write strobe stays high", m_wr, 0);
        chk("R4", "internal: address strobe pulses", m_ale, 1);
        chk("R7", "internal latency", m_lat, 4 + nw);
        if (w) exp_int[a[7:0]] = d;
        else chk("R4", "internal read data", int'(m_rdata), int'(exp_int[a[7:0]]));
    endtask

    logic wd_fired = 1'b0;

    initial begin
        #(4 * 200000);
        wd_fired = 1'b1;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  d;
        for (int i = 0; i < 1024; i++) begin ext_mem[i] = 8'h00; exp_ext[i] = 8'h00; end
        rst_n = 1'b0; xmem_en = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0;
        cpu_addr = 16'h0; cpu_wdata = 8'h0; wait_sel = 2'd0;
        port_ad_o = 8'hA5; port_ad_dir = 8'h3C; port_hi_o = 8'h5A; port_hi_dir = 8'hC3;
        port_ctl_o = 3'b111; port_ctl_dir = 3'b010;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state: strobes idle (bit0 low, bits 1,2 high), no ready.
        chk("R2", "reset control pins", int'(ctl_o), 3'b110);
        chk("R5", "reset control drive while enabled", int'(ctl_oe), 3'b111);
        chk("R7", "reset ready low", int'(cpu_ready), 0);

        // Internal memory fill while enabled (also seeds values for later reads).
        for (int i = 0; i < 16; i++) begin
            a = 16'(i * 17);
            d = 8'(~a[7:0] ^ 8'(i));
            int_acc(1'b1, a, d, i % 4);
        end
        for (int i = 0; i < 16; i++) begin
            a = 16'(i * 17);
            int_acc(1'b0, a, 8'h00, (i + 1) % 4);
        end

        // External sweep over all wait counts.
        for (int nw = 0; nw < 4; nw++) begin
            for (int i = 0; i < 8; i++) begin
                a = 16'h0100 + 16'((nw * 8 + i) * 23);
                d = a[7:0] ^ a[15:8] ^ 8'h5A ^ 8'(nw);
                ext_write(a, d, nw);
                ext_read(a, nw);
            end
        end

        // R10 boundary between internal and external.
        run_acc(1'b1, 16'h00FF, 8'h9E, 0, -1, -1);
        exp_int[8'hFF] = 8'h9E;
        chk("R10", "top address is internal (no write strobe)", m_wr, 0);
        run_acc(1'b1, 16'h0100, 8'h61, 0, -1, -1);
        exp_ext[10'h100] = 8'h61;
        chk("R10", "next address is external (write strobe)", m_wr, 1);
        int_acc(1'b0, 16'h00FF, 8'h00, 1);
        ext_read(16'h0100, 1);

        // Disabled: pins follow the port, above-top accesses hit nothing.
        xmem_en = 1'b0;
        run_acc(1'b1, 16'h0005, 8'h3C, 0, -1, -1);
        exp_int[8'h05] = 8'h3C;
        chk("R5", "pins follow port (internal write)", m_revert_bad, 0);
        run_acc(1'b1, 16'h0105, 8'hC3, 2, -1, -1);
        chk("R5", "pins follow port (above-top write)", m_revert_bad, 0);
        chk("R7", "disabled latency", m_lat, 6);
        run_acc(1'b0, 16'h0005, 8'h00, 0, -1, -1);
        chk("R6", "internal byte unchanged by above-top write", int'(m_rdata), 8'h3C);
        run_acc(1'b0, 16'h0105, 8'h00, 0, -1, -1);
        chk("R6", "above-top read while disabled returns 0", int'(m_rdata), 0);
        xmem_en = 1'b1;
        ext_read(16'h0105, 0);

        // R8: wait count fixed at acceptance.
        run_acc(1'b0, 16'h0100, 8'h00, 0, 2, -1);
        chk("R8", "latency after wait change", m_lat, 4);
        chk("R8", "strobe length after wait change", m_rd, 1);
        chk("R8", "data after wait change", int'(m_rdata), 8'h61);

        // R9: enable dropped in the first strobe cycle.
        run_acc(1'b0, 16'h0100, 8'h00, 2, -1, 3);
        chk("R9", "pins revert after enable drop", m_revert_bad, 0);
        chk("R9", "latency after enable drop", m_lat, 6);
        chk("R9", "ready still one cycle", int'(m_pulse_ok), 1);
        xmem_en = 1'b1;
        ext_read(16'h0100, 3);

        if (!wd_fired) begin
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule